// File: doc/BRIEF.md
# Indexed RTC Register Port with Interrupt Flags

This block is the host-facing register front end of a real-time clock. It holds a 128-byte register space behind just two host addresses. A write to the even address selects a byte by loading a 7-bit pointer. An access to the odd address then reads or writes the byte that pointer selects. Most bytes are plain storage. Four control bytes follow their own access rules.

- The status byte carries an update-busy bit that the host cannot write.
- The mode byte has a freeze bit. Setting it clears the busy bit and drops the update-ended enable.
- The flag byte collects event flags and clears itself when it is read.
- The last byte is read-only.

The time base outside this block sends single-cycle pulses: periodic tick, alarm match, update start and update ended. The block turns the gated events into flag bits and drives a level interrupt. That interrupt stays high until the host reads the flag byte. The block does no timekeeping arithmetic and no rate division.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (addr_i=0) stores wdata_i[6:0] as the pointer; bit 7 is dropped. A read of the even address returns 0xFF.
- R2: After reset the pointer is 0 and the control bytes read as follows: status (index 10) = 0x26, mode (index 11) = 0x02, flags (index 12) = 0x00, fixed (index 13) = 0x80. irq_o is low.
- R3: A host write to the status byte updates bits [6:0] and leaves bit 7 (update busy) unchanged.
- R4: An upd_start_i pulse sets status bit 7, but only while mode bit 7 (freeze) is 0. An ev_update_i pulse clears status bit 7.
- R5: A host write to the mode byte with bit 7 set clears status bit 7. It also stores mode bit 4 (update-ended enable) as 0, whatever the written value.
- R6: Host writes to the flag byte and to the fixed byte have no effect.
- R7: A read of the flag byte returns its current value. The byte is 0x00 from the next cycle on, and irq_o falls.
- R8: ev_periodic_i ORs 0xC0 into the flag byte. ev_alarm_i ORs 0xA0 when mode bit 5 is 1. ev_update_i ORs 0x90 when mode bit 4 is 1. Each of these raises irq_o in the next cycle.
- R9: An alarm pulse while mode bit 5 is 0 leaves both the flag byte and irq_o unchanged. The same holds for an update-ended pulse while mode bit 4 is 0.
- R10: If an event arrives in the same cycle as a flag-byte read, the event's bits are set after the read, and irq_o stays high.
- R11: Every index other than 10 to 13 is plain read/write storage. Each such index holds its own byte, and those bytes reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Host address bit: 0 for the pointer, 1 for data |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational from the current state |
| ev_periodic_i | input | 1 | Periodic tick pulse |
| ev_alarm_i | input | 1 | Alarm match pulse |
| ev_update_i | input | 1 | Update-ended pulse |
| upd_start_i | input | 1 | Update-started pulse |
| irq_o | output | 1 | Interrupt level |

## Verification
The bench builds the block with the default values, an 8-bit data path and a depth of 128. At that depth the 7-bit pointer covers the whole space, so a write of an 8-bit pointer value shows that bit 7 is dropped. The same default lets the bench reach storage bytes on both sides of the control bytes. Each event is applied with its enable bit both set and clear. One flag-byte read is placed in the same cycle as a periodic tick.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int unsigned IX_STAT  = 10;
  localparam int unsigned IX_MODE  = 11;
  localparam int unsigned IX_FLAG  = 12;
  localparam int unsigned IX_FIXED = 13;

  localparam int unsigned BIT_BUSY   = 7;
  localparam int unsigned BIT_FREEZE = 7;
  localparam int unsigned BIT_AEN    = 5;
  localparam int unsigned BIT_UEN    = 4;

  localparam logic [7:0] RST_STAT  = 8'h26;
  localparam logic [7:0] RST_MODE  = 8'h02;
  localparam logic [7:0] RST_FLAG  = 8'h00;
  localparam logic [7:0] RST_FIXED = 8'h80;

  localparam logic [7:0] MASK_PER = 8'hC0;
  localparam logic [7:0] MASK_ALM = 8'hA0;
  localparam logic [7:0] MASK_UPD = 8'h90;
endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (load_i) idx_o <= idx_i;
  end

  a_r1_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> idx_o == $past(idx_i));
endmodule

// File: rtl/rtc_gp_store.sv
module rtc_gp_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))          mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  a_r11_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regport_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_stat_i,
  input  logic       wr_mode_i,
  input  logic [7:0] wdata_i,
  input  logic       upd_start_i,
  input  logic       upd_done_i,
  output logic [7:0] stat_o,
  output logic [7:0] mode_o,
  output logic [7:0] fixed_o
);
  logic [6:0] stat_lo_q;
  logic       busy_q;
  logic [7:0] mode_q;
  logic       freeze_wr;

  assign freeze_wr = wr_mode_i && wdata_i[BIT_FREEZE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_lo_q <= RST_STAT[6:0];
    else if (wr_stat_i) stat_lo_q <= wdata_i[6:0];
  end

  // freeze write beats update-ended, which beats update start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   busy_q <= RST_STAT[BIT_BUSY];
    else if (freeze_wr)                            busy_q <= 1'b0;
    else if (upd_done_i)                           busy_q <= 1'b0;
    else if (upd_start_i && !mode_q[BIT_FREEZE])   busy_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= RST_MODE;
    else if (wr_mode_i) begin
      mode_q <= wdata_i;
      if (wdata_i[BIT_FREEZE]) mode_q[BIT_UEN] <= 1'b0;
    end
  end

  assign stat_o  = {busy_q, stat_lo_q};
  assign mode_o  = mode_q;
  assign fixed_o = RST_FIXED;

  a_r3_busy_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && !upd_start_i && !upd_done_i |=> $stable(stat_o[BIT_BUSY]));
  a_r5_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_wr |=> !stat_o[BIT_BUSY] && !mode_o[BIT_UEN]);
  a_r4_start_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_start_i && mode_o[BIT_FREEZE] && !wr_mode_i && !upd_done_i
      |=> $stable(stat_o[BIT_BUSY]));
  a_r4_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i |=> !stat_o[BIT_BUSY]);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_regport_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_flag_i,
  input  logic       ev_per_i,
  input  logic       ev_alm_i,
  input  logic       ev_upd_i,
  input  logic       alm_en_i,
  input  logic       upd_en_i,
  output logic [7:0] flag_o,
  output logic       irq_o
);
  logic [7:0] flag_q, set_mask;
  logic       irq_q, any_set;

  always_comb begin
    set_mask = '0;
    if (ev_per_i)             set_mask |= MASK_PER;
    if (ev_alm_i && alm_en_i) set_mask |= MASK_ALM;
    if (ev_upd_i && upd_en_i) set_mask |= MASK_UPD;
  end
  assign any_set = |set_mask;

  // new events win over read-clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST_FLAG;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= (rd_flag_i ? 8'h00 : flag_q) | set_mask;
      irq_q  <= any_set | (irq_q & ~rd_flag_i);
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_flag_i && !any_set |=> flag_o == 8'h00 && !irq_o);
  a_r8_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_set |=> irq_o);
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(any_set));
  a_r10_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_flag_i && any_set |=> irq_o && flag_o != 8'h00);
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REG_DEPTH = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ev_periodic_i,
  input  logic              ev_alarm_i,
  input  logic              ev_update_i,
  input  logic              upd_start_i,
  output logic              irq_o
);
  localparam int unsigned IDX_W = $clog2(REG_DEPTH);

  logic [IDX_W-1:0]  idx;
  logic              hit_stat, hit_mode, hit_flag, hit_fixed, hit_ctrl;
  logic              wr_data, rd_data;
  logic [7:0]        stat, mode, fixed, flags;
  logic [DATA_W-1:0] gp_rdata;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:IDX_W];

  assign wr_data   = wr_i && addr_i;
  assign rd_data   = rd_i && addr_i;
  assign hit_stat  = idx == IDX_W'(IX_STAT);
  assign hit_mode  = idx == IDX_W'(IX_MODE);
  assign hit_flag  = idx == IDX_W'(IX_FLAG);
  assign hit_fixed = idx == IDX_W'(IX_FIXED);
  assign hit_ctrl  = hit_stat | hit_mode | hit_flag | hit_fixed;

  rtc_index_reg #(.IDX_W(IDX_W)) u_index (
    .clk_i, .rst_ni,
    .load_i (wr_i && !addr_i),
    .idx_i  (wdata_i[IDX_W-1:0]),
    .idx_o  (idx)
  );

  rtc_gp_store #(.DATA_W(DATA_W), .DEPTH(REG_DEPTH)) u_store (
    .clk_i, .rst_ni,
    .we_i    (wr_data && !hit_ctrl),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .rdata_o (gp_rdata)
  );

  rtc_ctrl_regs u_ctrl (
    .clk_i, .rst_ni,
    .wr_stat_i   (wr_data && hit_stat),
    .wr_mode_i   (wr_data && hit_mode),
    .wdata_i     (wdata_i[7:0]),
    .upd_start_i (upd_start_i),
    .upd_done_i  (ev_update_i),
    .stat_o      (stat),
    .mode_o      (mode),
    .fixed_o     (fixed)
  );

  rtc_irq_flags u_flags (
    .clk_i, .rst_ni,
    .rd_flag_i (rd_data && hit_flag),
    .ev_per_i  (ev_periodic_i),
    .ev_alm_i  (ev_alarm_i),
    .ev_upd_i  (ev_update_i),
    .alm_en_i  (mode[BIT_AEN]),
    .upd_en_i  (mode[BIT_UEN]),
    .flag_o    (flags),
    .irq_o     (irq_o)
  );

  always_comb begin
    if (!addr_i)        rdata_o = '1;
    else if (hit_stat)  rdata_o = DATA_W'(stat);
    else if (hit_mode)  rdata_o = DATA_W'(mode);
    else if (hit_flag)  rdata_o = DATA_W'(flags);
    else if (hit_fixed) rdata_o = DATA_W'(fixed);
    else                rdata_o = gp_rdata;
  end

  a_r6_flag_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data && hit_flag && !ev_periodic_i && !ev_alarm_i && !ev_update_i
      |=> $stable(flags));
  a_r1_even_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> rdata_o == '1);
endmodule

// File: tb/rtc_regport_bench.sv
module rtc_regport_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic addr = 0, wr = 0, rd = 0, per = 0, alm = 0, upd = 0, ust = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq;

  int vectors = 0, miscompares = 0;
  int m_mem[128];
  int m_idx;
  bit m_irq;
  string tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regport u_rtc_regport (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .ev_periodic_i(per), .ev_alarm_i(alm),
    .ev_update_i(upd), .upd_start_i(ust), .irq_o(irq)
  );

  function automatic int model_read();
    return addr ? m_mem[m_idx] : 255;
  endfunction

  task automatic model_step();
    int b_old = m_mem[11];
    int a_old = m_mem[10];
    int busy  = a_old & 8'h80;
    int setm  = 0;
    if (wr && !addr) m_idx = wdata & 8'h7f;
    if (wr && addr) begin
      case (m_idx)
        10: m_mem[10] = (wdata & 8'h7f) | busy;
        11: m_mem[11] = (wdata & 8'h80) ? (wdata & 8'hEF) : wdata;
        12, 13: ;
        default: m_mem[m_idx] = wdata;
      endcase
    end
    if (wr && addr && m_idx == 11 && (wdata & 8'h80)) busy = 0;
    else if (upd) busy = 0;
    else if (ust && !(b_old & 8'h80)) busy = 8'h80;
    m_mem[10] = (m_mem[10] & 8'h7f) | busy;
    if (rd && addr && m_idx == 12) begin m_mem[12] = 0; m_irq = 0; end
    if (per) setm |= 8'hC0;
    if (alm && (b_old & 8'h20)) setm |= 8'hA0;
    if (upd && (b_old & 8'h10)) setm |= 8'h90;
    m_mem[12] |= setm;
    if (setm != 0) m_irq = 1;
  endtask

  task automatic step(bit a, bit w, bit r, logic [7:0] d,
                      bit p = 0, bit al = 0, bit u = 0, bit s = 0);
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d; per = p; alm = al; upd = u; ust = s;
    #1;
    vectors++;
    if (rdata !== 8'(model_read()) || irq !== m_irq) begin
      miscompares++;
      $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
               tag, rdata, irq, 8'(model_read()), m_irq);
    end
    @(posedge clk);
    model_step();
  endtask

  task automatic sel(int i);   step(0, 1, 0, 8'(i)); endtask
  task automatic put(int v);   step(1, 1, 0, 8'(v)); endtask
  task automatic get();        step(1, 0, 1, 8'h00); endtask
  task automatic idle();       step(1, 0, 0, 8'h00); endtask

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    m_mem[10] = 8'h26; m_mem[11] = 8'h02; m_mem[12] = 0; m_mem[13] = 8'h80;
    m_idx = 0; m_irq = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;

    tag = "R2"; for (int i = 10; i < 14; i++) begin sel(i); get(); end
    tag = "R1"; step(0, 0, 1, 8'h00);
    tag = "R11"; sel(20); put(8'h5A); get(); sel(9); put(8'h11); sel(14); put(8'h22);
    sel(9); get(); sel(14); get(); sel(127); get();
    tag = "R1"; sel(8'h8E); put(8'h33); sel(14); get();
    tag = "R4"; sel(10); step(1, 0, 1, 8'h00, 0, 0, 0, 1); get();
    tag = "R3"; put(8'h00); get(); put(8'h7F); get();
    tag = "R9"; step(1, 0, 0, 8'h00, 0, 0, 1, 0); get(); step(1, 0, 0, 8'h00, 0, 1, 0, 0);
    sel(12); get();
    tag = "R8"; step(1, 0, 0, 8'h00, 1, 0, 0, 0); idle();
    tag = "R7"; get(); get(); idle();
    tag = "R8"; sel(11); put(8'h32); sel(12);
    step(1, 0, 0, 8'h00, 0, 1, 0, 0); idle(); step(1, 0, 0, 8'h00, 0, 0, 1, 0); get(); get();
    tag = "R9"; sel(11); put(8'h12); sel(12); step(1, 0, 0, 8'h00, 0, 1, 0, 0); get();
    tag = "R5"; sel(10); step(1, 0, 0, 8'h00, 0, 0, 0, 1); get();
    sel(11); put(8'hB2); get(); sel(10); get();
    tag = "R4"; step(1, 0, 0, 8'h00, 0, 0, 0, 1); get();
    tag = "R9"; step(1, 0, 0, 8'h00, 0, 0, 1, 0); sel(12); get();
    tag = "R6"; step(1, 0, 0, 8'h00, 1, 0, 0, 0); put(8'h00); get(); put(8'hFF); get();
    sel(13); put(8'h00); get();
    tag = "R10"; sel(12); step(1, 0, 0, 8'h00, 1, 0, 0, 0);
    step(1, 0, 1, 8'h00, 1, 0, 0, 0); idle(); get(); idle();
    tag = "R11"; sel(20); get();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule